// File: doc/BRIEF.md
# Ethernet PHY Reset and Management Bring-Up Sequencer

This block controls the active-low hardware reset of an external Ethernet PHY and then prepares its management bus before any software transfer is let through. After system reset, and again on every hard-reset request, it holds the PHY in reset for a programmable number of clock cycles. It then waits a programmable settling interval and sends an idle burst of ones on the management data line. Next it probes the address the PHY is expected to use. The low time is programmable from microseconds to milliseconds, and the default is about 3 ms at 100 MHz. A long pulse is the default because a pulse near the minimum of about a microsecond can leave a warm-reset PHY unable to answer on the management bus.

A PHY samples its address straps when it leaves reset, so it may come back at a different address. When the expected address does not answer, the block reads the identifier register at all 32 addresses in ascending order and takes the first one that answers. It reports the address, the identifier and a done flag. If no address answers, it repeats the whole sequence up to a set number of times and then raises a fail flag. Once bring-up is done, a simple request port runs single clause-22 reads.

Top module: `phy_bringup_seq`

## Requirements
- R1: After a hard-reset request, `phy_rst_n_o` is low for exactly `RST_CYCLES` clock cycles. After system reset it is low for the whole reset plus at least `RST_CYCLES` cycles.
- R2: After `phy_rst_n_o` rises, at least `SETTLE_CYCLES` clock cycles pass before the first rising edge of `mdc_o`.
- R3: `mdc_o` is 0 whenever no management transfer is in progress, including throughout PHY reset. During a transfer each high phase and each low phase lasts `CLK_HALF` clock cycles (20 gives 2.5 MHz from 100 MHz).
- R4: After each PHY reset, the block sends 32 clock cycles with the data line high before the first frame. Every frame then starts with its own 32 ones, so 64 ones come before the first start pattern.
- R5: A read frame carries, MSB first, start `01`, opcode `10`, a 5-bit PHY address and a 5-bit register address. The block changes the data line only while `mdc_o` is low, releases it for the two turnaround bits, and samples 16 data bits, MSB first, on rising edges of `mdc_o`.
- R6: The first frame after the preamble reads register 2 at `EXPECT_ADDR`. If the value read is not 16'hFFFF, `done_o` rises with `phy_addr_o` and `phy_id_o` set to that address and value, and no scan follows. `done_o` and `fail_o` are never high together.
- R7: If the probe reads 16'hFFFF, register 2 is read at addresses 0, 1, 2 and so on. The scan stops at the first address that returns a value other than 16'hFFFF, and that address and value are reported.
- R8: If no address answers, the whole sequence (reset pulse, settle, preamble, probe, scan) runs again, up to `MAX_RETRY` extra times. After that `fail_o` goes high and stays high until a hard-reset request.
- R9: `req_reset_i` is accepted in any state. It stops any frame at once (the clock and the data-line drive both go low), clears `done_o`, `fail_o` and the retry count, and restarts the sequence.
- R10: While `done_o` is high, a pulse on `rd_req_i` reads register `rd_reg_i` of PHY `rd_phy_i`. The result appears on `rd_data_o` with a one-cycle pulse on `rd_ack_o`.
- R11: `mdio_oe_o` is low at all times except while the block drives preamble, start, opcode or address bits. It is low during turnaround, during the data bits and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| req_reset_i | input | 1 | Hard-reset request; restarts the sequence |
| rd_req_i | input | 1 | Read request, taken while done is high |
| rd_phy_i | input | 5 | PHY address for a read request |
| rd_reg_i | input | 5 | Register address for a read request |
| phy_rst_n_o | output | 1 | Active-low PHY reset |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (line with pull-up) |
| done_o | output | 1 | Bring-up succeeded |
| fail_o | output | 1 | No PHY found after all retries |
| phy_addr_o | output | 5 | Discovered PHY address |
| phy_id_o | output | 16 | Identifier value read at that address |
| rd_ack_o | output | 1 | One-cycle pulse: read result valid |
| rd_data_o | output | 16 | Read result |

## Verification
The assertions rely on a few things about the inputs. `req_reset_i` can arrive at any time. `rd_req_i` only matters while bring-up is done. `mdio_i` reads high whenever nobody drives the line, because of the external pull-up. The bench's PHY model drives the line only in the second turnaround bit and the data bits, changing it after falling edges of the clock, so the block's sampling on rising edges always sees a settled bit. All requests are single-cycle pulses applied on the falling clock edge.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_BITS  = 32;
  localparam int HDR_BITS  = 14;
  localparam int TA_BITS   = 2;
  localparam int DRV_END   = PRE_BITS + HDR_BITS;          // first released bit
  localparam int DATA_BEG  = DRV_END + TA_BITS;            // first data bit
  localparam int FRAME_END = DATA_BEG + DATA_W;            // bits in a read frame
  localparam logic [ADDR_W-1:0] ID_REG = 5'd2;

  typedef enum logic [2:0] {
    S_RST, S_SETTLE, S_PRE, S_PROBE, S_SCAN, S_DONE, S_READ, S_FAIL
  } seq_state_t;

  // start 01, read opcode 10, phy address, register address
  function automatic logic [HDR_BITS-1:0] rd_header(input logic [ADDR_W-1:0] phy,
                                                    input logic [ADDR_W-1:0] rg);
    return {2'b01, 2'b10, phy, rg};
  endfunction

  // value on the data line for bit slot idx of a frame
  function automatic logic frame_bit(input logic [5:0] idx, input logic [HDR_BITS-1:0] hdr);
    logic [5:0] k;
    k = 6'(DRV_END - 1) - idx;
    if (idx < 6'(PRE_BITS)) return 1'b1;
    if (idx < 6'(DRV_END))  return hdr[k[3:0]];
    return 1'b1;
  endfunction

  function automatic logic drives_slot(input logic [5:0] idx);
    return idx < 6'(DRV_END);
  endfunction

  function automatic logic id_present(input logic [DATA_W-1:0] v);
    return v != {DATA_W{1'b1}};
  endfunction

endpackage

// File: rtl/mdc_tick.sv
module mdc_tick #(
  parameter int CLK_HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(CLK_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CW'(CLK_HALF - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  mdc_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !mdc_o);

endmodule

// File: rtl/mdio_rd_frame.sv
module mdio_rd_frame
  import phy_bringup_pkg::*;
#(
  parameter int CLK_HALF = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              pre_only_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic              mdio_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic                busy_q, done_q;
  logic [5:0]          idx_q, last_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic [DATA_W-1:0]   sh_q, rdata_q;
  logic                rise_ev, fall_ev;

  mdc_tick #(.CLK_HALF(CLK_HALF)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (busy_q & ~abort_i),
    .mdc_o  (mdc_o),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          last_q <= pre_only_i ? 6'(PRE_BITS - 1) : 6'(FRAME_END - 1);
          hdr_q  <= rd_header(phy_i, reg_i);
        end
      end else begin
        if (rise_ev && idx_q >= 6'(DATA_BEG))
          sh_q <= {sh_q[DATA_W-2:0], mdio_i};
        if (fall_ev) begin
          if (idx_q == last_q) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            rdata_q <= sh_q;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign mdio_oe_o = busy_q && drives_slot(idx_q);
  assign mdio_o    = mdio_oe_o ? frame_bit(idx_q, hdr_q) : 1'b1;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;

  // R5
  drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && mdc_o |-> $stable(mdio_o) && $stable(mdio_oe_o));

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int                CLK_HALF      = 20,
  parameter int                RST_CYCLES    = 300000,
  parameter int                SETTLE_CYCLES = 20000,
  parameter logic [ADDR_W-1:0] EXPECT_ADDR   = 5'd0,
  parameter int                MAX_RETRY     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_phy_i,
  input  logic [ADDR_W-1:0] rd_reg_i,
  output logic              phy_rst_n_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic [15:0]       phy_id_o,
  output logic              rd_ack_o,
  output logic [15:0]       rd_data_o
);
  localparam int TMAX = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(MAX_RETRY + 2);

  seq_state_t        state_q;
  logic [TW-1:0]     tmr_q;
  logic [RW-1:0]     retry_q;
  logic              launched_q, up_q, ack_q;
  logic [ADDR_W-1:0] tgt_phy_q, tgt_reg_q, addr_q;
  logic [DATA_W-1:0] id_q, rd_q;

  logic              frm_start, frm_busy, frm_done, in_frame;
  logic [DATA_W-1:0] frm_data;

  assign in_frame  = (state_q == S_PRE) || (state_q == S_PROBE) ||
                     (state_q == S_SCAN) || (state_q == S_READ);
  assign frm_start = in_frame && !launched_q && !req_reset_i;

  mdio_rd_frame #(.CLK_HALF(CLK_HALF)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (frm_start),
    .abort_i    (req_reset_i),
    .pre_only_i (state_q == S_PRE),
    .phy_i      (tgt_phy_q),
    .reg_i      (tgt_reg_q),
    .mdio_i     (mdio_i),
    .mdc_o      (mdc_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .busy_o     (frm_busy),
    .done_o     (frm_done),
    .rdata_o    (frm_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_RST;
      tmr_q      <= '0;
      retry_q    <= '0;
      launched_q <= 1'b0;
      up_q       <= 1'b0;
      ack_q      <= 1'b0;
      tgt_phy_q  <= '0;
      tgt_reg_q  <= ID_REG;
      addr_q     <= '0;
      id_q       <= '0;
      rd_q       <= '0;
    end else begin
      ack_q <= 1'b0;
      if (req_reset_i) begin
        state_q    <= S_RST;
        tmr_q      <= '0;
        retry_q    <= '0;
        launched_q <= 1'b0;
        up_q       <= 1'b0;
        addr_q     <= '0;
        id_q       <= '0;
      end else begin
        case (state_q)
          S_RST: begin
            if (tmr_q == TW'(RST_CYCLES - 1)) begin
              tmr_q   <= '0;
              state_q <= S_SETTLE;
            end else tmr_q <= tmr_q + 1'b1;
          end
          S_SETTLE: begin
            if (tmr_q == TW'(SETTLE_CYCLES - 1)) begin
              tmr_q   <= '0;
              state_q <= S_PRE;
            end else tmr_q <= tmr_q + 1'b1;
          end
          S_DONE: begin
            if (rd_req_i) begin
              tgt_phy_q <= rd_phy_i;
              tgt_reg_q <= rd_reg_i;
              state_q   <= S_READ;
            end
          end
          S_FAIL: ;
          default: begin
            if (!launched_q) launched_q <= 1'b1;
            else if (frm_done) begin
              launched_q <= 1'b0;
              case (state_q)
                S_PRE: begin
                  tgt_phy_q <= EXPECT_ADDR;
                  tgt_reg_q <= ID_REG;
                  state_q   <= S_PROBE;
                end
                S_READ: begin
                  rd_q    <= frm_data;
                  ack_q   <= 1'b1;
                  state_q <= S_DONE;
                end
                default: begin
                  if (id_present(frm_data)) begin
                    addr_q  <= tgt_phy_q;
                    id_q    <= frm_data;
                    up_q    <= 1'b1;
                    state_q <= S_DONE;
                  end else if (state_q == S_PROBE) begin
                    tgt_phy_q <= '0;
                    state_q   <= S_SCAN;
                  end else if (tgt_phy_q != {ADDR_W{1'b1}}) begin
                    tgt_phy_q <= tgt_phy_q + 1'b1;
                  end else if (retry_q < RW'(MAX_RETRY)) begin
                    retry_q <= retry_q + 1'b1;
                    tmr_q   <= '0;
                    state_q <= S_RST;
                  end else begin
                    state_q <= S_FAIL;
                  end
                end
              endcase
            end
          end
        endcase
      end
    end
  end

  assign phy_rst_n_o = (state_q != S_RST);
  assign done_o      = up_q;
  assign fail_o      = (state_q == S_FAIL);
  assign phy_addr_o  = addr_q;
  assign phy_id_o    = id_q;
  assign rd_ack_o    = ack_q;
  assign rd_data_o   = rd_q;

  // R1
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n_o) |-> $past(tmr_q) == TW'(RST_CYCLES - 1));
  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_busy |-> !mdc_o);
  // R9
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst_n_o |-> !mdc_o && !mdio_oe_o);
  // R6
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));
  // R8
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= RW'(MAX_RETRY));
  // R10
  rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack_o |-> done_o && $past(state_q == S_READ));

endmodule

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb_top;
  localparam int         HALF   = 2;
  localparam int         RSTC   = 40;
  localparam int         SETC   = 16;
  localparam logic [4:0] EXP    = 5'd1;
  localparam int         RETRY  = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_reset, rd_req;
  logic [4:0]  rd_phy, rd_reg;
  logic        phy_rst_n_o, mdc_o, mdio_o, mdio_oe_o;
  logic        done_o, fail_o, rd_ack_o;
  logic [4:0]  phy_addr_o;
  logic [15:0] phy_id_o, rd_data_o;
  logic        phy_drv = 1'b0, phy_bit = 1'b1;
  wire         mdio_line = mdio_oe_o ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  phy_bringup_seq #(.CLK_HALF(HALF), .RST_CYCLES(RSTC), .SETTLE_CYCLES(SETC),
                    .EXPECT_ADDR(EXP), .MAX_RETRY(RETRY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_reset_i(req_reset), .rd_req_i(rd_req),
    .rd_phy_i(rd_phy), .rd_reg_i(rd_reg), .phy_rst_n_o(phy_rst_n_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_line), .done_o(done_o),
    .fail_o(fail_o), .phy_addr_o(phy_addr_o), .phy_id_o(phy_id_o),
    .rd_ack_o(rd_ack_o), .rd_data_o(rd_data_o));

  int checks = 0, fails = 0;
  // PHY model settings
  int model_on = 1, model_addr = 1, need = 0, base = 0;
  logic [15:0] model_id = 16'h2000;
  // observations
  int pulses = 0, epoch = 0;
  int frames = 0, bad_frames = 0, bad_op = 0, last_addr = -1, last_reg = -1;
  int first_ones = -1, last_ones = -1;
  int lowcnt = 0, last_low = 0, gap = 0, last_gap = -1, hi_cnt = 0, hi_bad = 0, clash = 0;
  logic gap_armed = 1'b0;

  always @(negedge phy_rst_n_o) begin pulses++; epoch++; end

  // model receiver, samples on rising MDC
  int mst = 0, ones = 0, hcnt = 0, tcnt = 0, dcnt = 0, my_epoch = 0;
  logic first = 1'b1, respond = 1'b0;
  logic [11:0] hdr = '0;
  logic [15:0] resp = '0;
  always @(posedge mdc_o) begin
    if (my_epoch != epoch) begin my_epoch = epoch; mst = 0; ones = 0; first = 1'b1; end
    case (mst)
      0: if (mdio_line) ones++;
         else begin
           if (ones >= 32) begin
             if (first) first_ones = ones;
             first = 1'b0; last_ones = ones; mst = 1;
           end
           ones = 0;
         end
      1: if (mdio_line) begin mst = 2; hcnt = 0; end else begin mst = 0; bad_frames++; end
      2: begin
           hdr = {hdr[10:0], mdio_line}; hcnt++;
           if (hcnt == 12) begin
             frames++; mst = 3; tcnt = 0;
             if (hdr[11:10] != 2'b10) bad_op++;
             last_addr = int'(hdr[9:5]); last_reg = int'(hdr[4:0]);
             respond = model_on != 0 && (pulses - base) >= need && int'(hdr[9:5]) == model_addr;
             resp = (hdr[4:0] == 5'd2) ? model_id : {6'h2A, hdr[4:0], hdr[9:5]};
           end
         end
      3: begin tcnt++; if (tcnt == 2) begin mst = 4; dcnt = 0; end end
      default: begin dcnt++; if (dcnt == 16) begin mst = 0; ones = 0; end end
    endcase
  end

  // model driver, changes after falling MDC
  always @(negedge mdc_o) begin
    if (mst == 3 && tcnt == 1 && respond) begin phy_drv <= 1'b1; phy_bit <= 1'b0; end
    else if (mst == 4 && dcnt < 16 && respond) begin phy_drv <= 1'b1; phy_bit <= resp[15-dcnt]; end
    else begin phy_drv <= 1'b0; phy_bit <= 1'b1; end
  end

  always @(posedge clk) begin
    if (!phy_rst_n_o) begin lowcnt++; gap = 0; gap_armed = 1'b1; end
    else begin
      if (lowcnt != 0) begin last_low = lowcnt; lowcnt = 0; end
      if (gap_armed) begin
        if (mdc_o) begin last_gap = gap; gap_armed = 1'b0; end else gap++;
      end
    end
    if (mdc_o) hi_cnt++;
    else if (hi_cnt != 0) begin if (hi_cnt != HALF) hi_bad++; hi_cnt = 0; end
    if (mdio_oe_o && phy_drv) clash++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic hard_reset();
    @(negedge clk) req_reset = 1'b1;
    @(negedge clk) req_reset = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (done_o || fail_o) break;
    end
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r, output logic [15:0] d,
                         output int acks);
    acks = 0; d = '0;
    @(negedge clk) begin rd_req = 1'b1; rd_phy = p; rd_reg = r; end
    @(negedge clk) rd_req = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (rd_ack_o) begin acks++; d = rd_data_o; @(negedge clk); if (rd_ack_o) acks++; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_power_on();
    int fb;
    model_on = 1; model_addr = int'(EXP); model_id = 16'h2000; need = 0; base = pulses;
    fb = frames;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(!phy_rst_n_o && !mdc_o && !mdio_oe_o && !done_o && !fail_o, "R1 reset state", 0, 0);
    rst_n = 1'b1;
    wait_end();
    chk(last_low >= RSTC, "R1 power-on low time", last_low, RSTC);
    chk(last_gap >= SETC, "R2 settle gap", last_gap, SETC);
    chk(first_ones == 64, "R4 ones before first start", first_ones, 64);
    chk(done_o && phy_addr_o == EXP, "R6 probe address", int'(phy_addr_o), int'(EXP));
    chk(phy_id_o == 16'h2000, "R6 probe id", int'(phy_id_o), 16'h2000);
    chk(frames - fb == 1, "R6 no scan", frames - fb, 1);
    chk(bad_frames == 0 && bad_op == 0 && last_reg == 2, "R5 frame fields", bad_frames + bad_op, 0);
  endtask

  task automatic t_moved();
    int fb;
    model_addr = 9; model_id = 16'hA0F1; base = pulses; fb = frames;
    hard_reset();
    chk(!done_o && !phy_rst_n_o, "R9 request clears done", int'(done_o), 0);
    wait_end();
    chk(last_low == RSTC, "R1 hard reset low time", last_low, RSTC);
    chk(phy_addr_o == 5'd9 && phy_id_o == 16'hA0F1, "R7 scanned address", int'(phy_addr_o), 9);
    chk(frames - fb == 11, "R7 scan frame count", frames - fb, 11);
    chk(last_addr == 9 && last_reg == 2, "R7 last address read", last_addr, 9);
    chk(first_ones == 64, "R4 preamble after hard reset", first_ones, 64);
  endtask

  task automatic t_absent();
    int fb;
    model_on = 0; base = pulses; fb = frames;
    hard_reset();
    wait_end();
    chk(fail_o && !done_o, "R8 fail flag", int'(fail_o), 1);
    chk(pulses - base == RETRY + 1, "R8 reset pulses", pulses - base, RETRY + 1);
    chk(frames - fb == 33 * (RETRY + 1), "R8 frames over retries", frames - fb, 33 * (RETRY + 1));
    chk(last_addr == 31, "R7 scan reaches 31", last_addr, 31);
    repeat (50) @(negedge clk);
    chk(fail_o && !mdc_o, "R8 fail holds", int'(fail_o), 1);
  endtask

  task automatic t_retry();
    model_on = 1; model_addr = int'(EXP); model_id = 16'h2000; need = 2; base = pulses;
    hard_reset();
    wait_end();
    chk(done_o && phy_addr_o == EXP, "R8 success on retry", int'(phy_addr_o), int'(EXP));
    chk(pulses - base == 2, "R8 pulses before success", pulses - base, 2);
  endtask

  task automatic t_read();
    logic [15:0] d; int acks;
    do_read(EXP, 5'd3, d, acks);
    chk(d == {6'h2A, 5'd3, EXP}, "R10 read register 3", int'(d), int'({6'h2A, 5'd3, EXP}));
    chk(acks == 1, "R10 single ack", acks, 1);
    chk(last_addr == int'(EXP) && last_reg == 3, "R5 read header", last_reg, 3);
    do_read(EXP, 5'd2, d, acks);
    chk(d == 16'h2000, "R10 read id", int'(d), 16'h2000);
    do_read(5'd7, 5'd2, d, acks);
    chk(d == 16'hFFFF && done_o, "R10 absent address", int'(d), 16'hFFFF);
  endtask

  task automatic t_abort();
    model_on = 0; base = pulses;
    hard_reset();
    repeat (600) @(negedge clk);
    chk(mdc_o || mdio_oe_o || dut_i.phy_rst_n_o, "R9 mid-scan", 1, 1);
    @(negedge clk) req_reset = 1'b1;
    @(negedge clk) req_reset = 1'b0;
    chk(!mdc_o && !mdio_oe_o && !phy_rst_n_o, "R9 abort quiet", int'(mdc_o), 0);
    model_on = 1; model_addr = int'(EXP); need = 0;
    wait_end();
    chk(done_o && last_low == RSTC, "R9 restart after abort", last_low, RSTC);
  endtask

  initial begin
    rst_n = 1'b0; req_reset = 1'b0; rd_req = 1'b0; rd_phy = '0; rd_reg = '0;
    t_power_on();
    t_moved();
    t_absent();
    t_retry();
    t_read();
    t_abort();
    chk(hi_bad == 0, "R3 clock phase length", hi_bad, 0);
    chk(clash == 0, "R11 no drive overlap", clash, 0);
    @(negedge clk);
    chk(!mdio_oe_o && !mdc_o, "R11 released when idle", int'(mdio_oe_o), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule